// File: doc/BRIEF.md
# Debug Channel Interrupt Enable Register

This block is a 64-bit system register that holds two interrupt-enable bits for a debug communications channel and drives one combined interrupt request. The channel supplies a receive-full flag and a transmit-full flag. With the receive enable set, the request is raised while the receive side holds data. With the transmit enable set, the request is raised while the transmit side has room. Both sources drive the same single output.

Every access to the register is checked before it takes effect. The check uses the current privilege level, a debug-halted input, and trap-control bits owned by privilege levels 2 and 3. Each access ends one of three ways:
- it completes;
- it is undefined;
- it is trapped to level 2 or level 3 with syndrome 0x18.

An access that does not complete changes nothing, and a read that does not complete returns zero. The result of each access appears one clock after the request, for exactly one cycle.

Top module: `dcc_irq_enable_reg`

## Requirements
- R1: A synchronous reset clears both enable bits. After reset `irq_comb` is 0 for any flag values, and a completed read returns 0.
- R2: When bit 30 (receive enable) is 1, `irq_comb` is 1 while `rx_full` is 1.
- R3: When bit 29 (transmit enable) is 1, `irq_comb` is 1 while `tx_full` is 0. When neither enabled source is active, `irq_comb` is 0.
- R4: Only bits 30 and 29 are writable. Every other bit reads as zero and ignores writes, so writing all ones reads back as 0x0000_0000_6000_0000.
- R5: The register responds only to the encoding op0=2, op1=0, CRn=0, CRm=2, op2=0. Any other encoding gives no response and changes no state.
- R6: Any access at level 0 is undefined: `resp_kind`=01 and `fault_undef` pulses. This holds even when the core is halted.
- R7: At levels 1 to 3, when `core_halted` and `ignore_traps_halted` are both 1, the access completes (`resp_kind`=00) whatever the trap bits are.
- R8: At level 1 and level 2, a level-3 trap with `l3_undef_prio`=1 gives undefined. This check comes first and wins over every level-2 trap. The comms form of the trap needs `fine_trap_feat`. Every level-3 check needs `have_level3`.
- R9: At level 1 with `level2_enabled`=1, the access traps to level 2 (`resp_kind`=10, `resp_level`=2, syndrome 0x18) when either of these holds:
  - `l2_comm_trap` is set and `fine_trap_feat` is 1;
  - `l2_dbgexc_route` or `l2_debug_trap` is set.
- R10: After the earlier checks, a level-3 comms trap (with `fine_trap_feat`) or a level-3 debug trap sends the access to level 3 with syndrome 0x18. The access is undefined instead if `l3_sdd_undef` is 1. With `have_level3`=0 the level-3 bits have no effect.
- R11: At level 2 the level-2 trap bits are skipped. At level 3 every access completes.
- R12: A write that does not complete leaves the register unchanged. A read that does not complete returns 0 on `rd_data`. In both cases exactly one of `fault_undef` and `fault_trap` is 1, for one cycle.
- R13: The response (`resp_valid`, kind, level, syndrome, data) appears in the cycle after the request and lasts one cycle. A completed write is reflected in `irq_comb` from that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_wdata | input | 64 | Write data |
| cur_level | input | 2 | Privilege level of the access (0..3) |
| core_halted | input | 1 | Core is halted in debug |
| ignore_traps_halted | input | 1 | Option to ignore traps while halted |
| have_level3 | input | 1 | Level 3 is implemented |
| fine_trap_feat | input | 1 | Fine-grained trap feature is present |
| level2_enabled | input | 1 | Level 2 is enabled for this access |
| l3_undef_prio | input | 1 | Level-3 traps give undefined with top priority |
| l3_sdd_undef | input | 1 | Secure debug disabled: level-3 traps become undefined |
| l3_comm_trap | input | 1 | Level-3 debug-comms trap bit |
| l3_debug_trap | input | 1 | Level-3 debug-access trap bit |
| l2_comm_trap | input | 1 | Level-2 debug-comms trap bit |
| l2_dbgexc_route | input | 1 | Level-2 debug-exception routing bit |
| l2_debug_trap | input | 1 | Level-2 debug-access trap bit |
| rx_full | input | 1 | Channel receive-full flag |
| tx_full | input | 1 | Channel transmit-full flag |
| resp_valid | output | 1 | Response valid (one cycle) |
| resp_kind | output | 2 | 00 completed, 01 undefined, 10 trapped |
| resp_level | output | 2 | Trap target level (2 or 3), 0 otherwise |
| resp_syndrome | output | 6 | 0x18 on a trap, 0 otherwise |
| rd_data | output | 64 | Read data, 0 unless a completed read |
| fault_undef | output | 1 | One-cycle undefined pulse |
| fault_trap | output | 1 | One-cycle trap pulse |
| irq_comb | output | 1 | Combined channel interrupt request |

## Verification
The only stored state is the two enable bits. A corrupted enable shows up at once on `irq_comb` for a suitable flag value. It also shows on `rd_data` in the cycle after a completed read. A wrong verdict from the access ladder shows in the response cycle as a wrong kind, level or syndrome, or as a write that should have been blocked. That wrong write is then visible on the next read and on the interrupt. The directed cases set up each rung of the ladder so that two candidate outcomes compete, which exposes any error in the ordering.

// File: rtl/dcc_ie_pkg.sv
package dcc_ie_pkg;

    localparam logic [1:0] ENC_OP0 = 2'd2;
    localparam logic [2:0] ENC_OP1 = 3'd0;
    localparam logic [3:0] ENC_CRN = 4'd0;
    localparam logic [3:0] ENC_CRM = 4'd2;
    localparam logic [2:0] ENC_OP2 = 3'd0;

    typedef enum logic [1:0] {
        RESP_DONE  = 2'b00,
        RESP_UNDEF = 2'b01,
        RESP_TRAP  = 2'b10
    } resp_kind_e;

    typedef struct packed {
        logic have_l3;
        logic fgt;
        logic l2_on;
        logic l3_prio;
        logic l3_sdd;
        logic l3_comm;
        logic l3_dbg;
        logic l2_comm;
        logic l2_tde;
        logic l2_tda;
    } trap_ctl_t;

    typedef struct packed {
        resp_kind_e kind;
        logic [1:0] level;
    } verdict_t;

    function automatic logic enc_match(input logic [1:0] op0, input logic [2:0] op1,
                                       input logic [3:0] crn, input logic [3:0] crm,
                                       input logic [2:0] op2);
        return (op0 == ENC_OP0) && (op1 == ENC_OP1) && (crn == ENC_CRN) &&
               (crm == ENC_CRM) && (op2 == ENC_OP2);
    endfunction

    // Fixed-priority access ladder
    function automatic verdict_t judge(input logic [1:0] lvl, input logic halted,
                                       input logic ign, input trap_ctl_t t);
        verdict_t v;
        logic l3c, l3d, l2c, l2d;
        l3c = t.have_l3 & t.fgt & t.l3_comm;
        l3d = t.have_l3 & t.l3_dbg;
        l2c = t.l2_on & t.fgt & t.l2_comm;
        l2d = t.l2_on & (t.l2_tde | t.l2_tda);
        v.kind  = RESP_DONE;
        v.level = 2'd0;
        if (lvl == 2'd0) begin
            v.kind = RESP_UNDEF;
        end else if (halted && ign) begin
            v.kind = RESP_DONE;
        end else if (lvl == 2'd3) begin
            v.kind = RESP_DONE;
        end else if (l3c && t.l3_prio) begin
            v.kind = RESP_UNDEF;
        end else if (l3d && t.l3_prio) begin
            v.kind = RESP_UNDEF;
        end else if (lvl == 2'd1 && (l2c || l2d)) begin
            v.kind  = RESP_TRAP;
            v.level = 2'd2;
        end else if (l3c || l3d) begin
            if (t.l3_sdd) begin
                v.kind = RESP_UNDEF;
            end else begin
                v.kind  = RESP_TRAP;
                v.level = 2'd3;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/dcc_ie_gate.sv
module dcc_ie_gate
    import dcc_ie_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    input  logic [1:0] lvl,
    input  logic       halted,
    input  logic       ign,
    input  trap_ctl_t  ctl,
    output logic       hit,
    output verdict_t   verdict
);
    always_comb begin
        hit     = valid && enc_match(op0, op1, crn, crm, op2);
        verdict = judge(lvl, halted, ign, ctl);
    end
endmodule

// File: rtl/dcc_ie_store.sv
module dcc_ie_store #(
    parameter int REG_W  = 64,
    parameter int RX_POS = 30,
    parameter int TX_POS = 29
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [1:0]       en_q,
    output logic [REG_W-1:0] rd_val
);
    localparam int N_EN = 2;
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    for (genvar g = 0; g < N_EN; g++) begin : g_en
        localparam int POS = (g == 1) ? RX_POS : TX_POS;
        always_ff @(posedge clk) begin
            if (rst)        en_q[g] <= 1'b0;
            else if (wr_en) en_q[g] <= wdata[POS];
        end
    end

    always_comb begin
        rd_val         = '0;
        rd_val[RX_POS] = en_q[1];
        rd_val[TX_POS] = en_q[0];
    end
endmodule

// File: rtl/dcc_ie_irq.sv
module dcc_ie_irq #(
    parameter int                N_SRC   = 2,
    parameter logic [N_SRC-1:0] ACT_LVL = 2'b10
) (
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] flag,
    output logic             irq
);
    logic [N_SRC-1:0] src_hit;
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign src_hit[g] = en[g] & (flag[g] == ACT_LVL[g]);
    end
    assign irq = |src_hit;
endmodule

// File: rtl/dcc_ie_resp.sv
module dcc_ie_resp
    import dcc_ie_pkg::*;
#(
    parameter int              REG_W   = 64,
    parameter int              EC_W    = 6,
    parameter logic [EC_W-1:0] TRAP_EC = 'h18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             is_write,
    input  verdict_t         verdict,
    input  logic [REG_W-1:0] rd_val,
    output logic             resp_valid,
    output logic [1:0]       resp_kind,
    output logic [1:0]       resp_level,
    output logic [EC_W-1:0]  resp_syndrome,
    output logic [REG_W-1:0] rd_data,
    output logic             fault_undef,
    output logic             fault_trap
);
    always_ff @(posedge clk) begin
        if (rst || !hit) begin
            resp_valid    <= 1'b0;
            resp_kind     <= RESP_DONE;
            resp_level    <= 2'd0;
            resp_syndrome <= '0;
            rd_data       <= '0;
            fault_undef   <= 1'b0;
            fault_trap    <= 1'b0;
        end else begin
            resp_valid    <= 1'b1;
            resp_kind     <= verdict.kind;
            resp_level    <= verdict.level;
            resp_syndrome <= (verdict.kind == RESP_TRAP) ? TRAP_EC : '0;
            rd_data       <= (verdict.kind == RESP_DONE && !is_write) ? rd_val : '0;
            fault_undef   <= (verdict.kind == RESP_UNDEF);
            fault_trap    <= (verdict.kind == RESP_TRAP);
        end
    end
endmodule

// File: rtl/dcc_irq_enable_reg.sv
module dcc_irq_enable_reg
    import dcc_ie_pkg::*;
#(
    parameter int              REG_W   = 64,
    parameter int              RX_POS  = 30,
    parameter int              TX_POS  = 29,
    parameter int              EC_W    = 6,
    parameter logic [EC_W-1:0] TRAP_EC = 'h18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [1:0]       acc_op0,
    input  logic [2:0]       acc_op1,
    input  logic [3:0]       acc_crn,
    input  logic [3:0]       acc_crm,
    input  logic [2:0]       acc_op2,
    input  logic [REG_W-1:0] acc_wdata,
    input  logic [1:0]       cur_level,
    input  logic             core_halted,
    input  logic             ignore_traps_halted,
    input  logic             have_level3,
    input  logic             fine_trap_feat,
    input  logic             level2_enabled,
    input  logic             l3_undef_prio,
    input  logic             l3_sdd_undef,
    input  logic             l3_comm_trap,
    input  logic             l3_debug_trap,
    input  logic             l2_comm_trap,
    input  logic             l2_dbgexc_route,
    input  logic             l2_debug_trap,
    input  logic             rx_full,
    input  logic             tx_full,
    output logic             resp_valid,
    output logic [1:0]       resp_kind,
    output logic [1:0]       resp_level,
    output logic [EC_W-1:0]  resp_syndrome,
    output logic [REG_W-1:0] rd_data,
    output logic             fault_undef,
    output logic             fault_trap,
    output logic             irq_comb
);
    trap_ctl_t        ctl;
    verdict_t         verdict;
    logic             hit;
    logic             wr_commit;
    logic [1:0]       en_bits;
    logic [REG_W-1:0] rd_val;

    always_comb begin
        ctl.have_l3 = have_level3;
        ctl.fgt     = fine_trap_feat;
        ctl.l2_on   = level2_enabled;
        ctl.l3_prio = l3_undef_prio;
        ctl.l3_sdd  = l3_sdd_undef;
        ctl.l3_comm = l3_comm_trap;
        ctl.l3_dbg  = l3_debug_trap;
        ctl.l2_comm = l2_comm_trap;
        ctl.l2_tde  = l2_dbgexc_route;
        ctl.l2_tda  = l2_debug_trap;
    end

    dcc_ie_gate u_gate (
        .valid(acc_valid), .op0(acc_op0), .op1(acc_op1), .crn(acc_crn),
        .crm(acc_crm), .op2(acc_op2), .lvl(cur_level), .halted(core_halted),
        .ign(ignore_traps_halted), .ctl(ctl), .hit(hit), .verdict(verdict)
    );

    assign wr_commit = hit && acc_write && (verdict.kind == RESP_DONE);

    dcc_ie_store #(.REG_W(REG_W), .RX_POS(RX_POS), .TX_POS(TX_POS)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_commit), .wdata(acc_wdata),
        .en_q(en_bits), .rd_val(rd_val)
    );

    dcc_ie_irq #(.N_SRC(2), .ACT_LVL(2'b10)) u_irq (
        .en(en_bits), .flag({rx_full, tx_full}), .irq(irq_comb)
    );

    dcc_ie_resp #(.REG_W(REG_W), .EC_W(EC_W), .TRAP_EC(TRAP_EC)) u_resp (
        .clk(clk), .rst(rst), .hit(hit), .is_write(acc_write), .verdict(verdict),
        .rd_val(rd_val), .resp_valid(resp_valid), .resp_kind(resp_kind),
        .resp_level(resp_level), .resp_syndrome(resp_syndrome), .rd_data(rd_data),
        .fault_undef(fault_undef), .fault_trap(fault_trap)
    );
endmodule

// File: rtl/dcc_ie_chk.sv
module dcc_ie_chk
    import dcc_ie_pkg::*;
#(
    parameter int REG_W = 64,
    parameter int EC_W  = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic             acc_write,
    input logic [1:0]       acc_op0,
    input logic [2:0]       acc_op1,
    input logic [3:0]       acc_crn,
    input logic [3:0]       acc_crm,
    input logic [2:0]       acc_op2,
    input logic [1:0]       cur_level,
    input logic             rx_full,
    input logic             tx_full,
    input logic             resp_valid,
    input logic [1:0]       resp_kind,
    input logic [1:0]       resp_level,
    input logic [EC_W-1:0]  resp_syndrome,
    input logic [REG_W-1:0] rd_data,
    input logic             fault_undef,
    input logic             fault_trap,
    input logic             irq_comb,
    input logic [1:0]       en_state
);
    logic req_hit;
    assign req_hit = acc_valid && enc_match(acc_op0, acc_op1, acc_crn, acc_crm, acc_op2);

    // R1
    reset_clears_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !irq_comb);

    // R2
    rx_source_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (en_state[1] && rx_full) |-> irq_comb);

    // R3
    tx_source_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (en_state[0] && !tx_full) |-> irq_comb);

    // R6
    level0_undef_chk: assert property (@(posedge clk) disable iff (rst)
        (req_hit && cur_level == 2'd0) |=> (resp_valid && resp_kind == RESP_UNDEF));

    // R11
    level3_done_chk: assert property (@(posedge clk) disable iff (rst)
        (req_hit && cur_level == 2'd3) |=> (resp_valid && resp_kind == RESP_DONE));

    // R11
    level2_no_l2trap_chk: assert property (@(posedge clk) disable iff (rst)
        (req_hit && cur_level == 2'd2) |=> !(resp_kind == RESP_TRAP && resp_level == 2'd2));

    // R12
    fault_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fault_undef, fault_trap}));

    // R12
    fault_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind != RESP_DONE) |-> (rd_data == '0));

    // R12
    fault_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind != RESP_DONE) |-> $stable(en_state));

    // R9
    trap_syndrome_chk: assert property (@(posedge clk) disable iff (rst)
        fault_trap |-> (resp_syndrome == 'h18 && (resp_level == 2'd2 || resp_level == 2'd3)));

    // R13
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(req_hit));
endmodule

bind dcc_irq_enable_reg dcc_ie_chk #(.REG_W(REG_W), .EC_W(EC_W)) i_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm),
    .acc_op2(acc_op2), .cur_level(cur_level), .rx_full(rx_full), .tx_full(tx_full),
    .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_level(resp_level),
    .resp_syndrome(resp_syndrome), .rd_data(rd_data), .fault_undef(fault_undef),
    .fault_trap(fault_trap), .irq_comb(irq_comb), .en_state(en_bits)
);

// File: tb/test_dcc_irq_enable_reg.sv
module test_dcc_irq_enable_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 0, acc_write = 0;
    logic [1:0]  acc_op0 = 2'd2;
    logic [2:0]  acc_op1 = 3'd0;
    logic [3:0]  acc_crn = 4'd0;
    logic [3:0]  acc_crm = 4'd2;
    logic [2:0]  acc_op2 = 3'd0;
    logic [63:0] acc_wdata = '0;
    logic [1:0]  cur_level = 2'd3;
    logic core_halted = 0, ignore_traps_halted = 0;
    logic have_level3 = 0, fine_trap_feat = 0, level2_enabled = 0;
    logic l3_undef_prio = 0, l3_sdd_undef = 0, l3_comm_trap = 0, l3_debug_trap = 0;
    logic l2_comm_trap = 0, l2_dbgexc_route = 0, l2_debug_trap = 0;
    logic rx_full = 0, tx_full = 1;
    logic        resp_valid, fault_undef, fault_trap, irq_comb;
    logic [1:0]  resp_kind, resp_level;
    logic [5:0]  resp_syndrome;
    logic [63:0] rd_data;

    int checks = 0, errors = 0;
    bit done = 0;

    localparam logic [63:0] BOTH = 64'h0000_0000_6000_0000;
    localparam logic [63:0] RXB  = 64'h0000_0000_4000_0000;
    localparam logic [63:0] TXB  = 64'h0000_0000_2000_0000;

    always #4 clk = ~clk;

    dcc_irq_enable_reg i_dcc_irq_enable_reg (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr_ctl();
        core_halted = 0; ignore_traps_halted = 0; have_level3 = 0; fine_trap_feat = 0;
        level2_enabled = 0; l3_undef_prio = 0; l3_sdd_undef = 0; l3_comm_trap = 0;
        l3_debug_trap = 0; l2_comm_trap = 0; l2_dbgexc_route = 0; l2_debug_trap = 0;
        acc_crm = 4'd2;
    endtask

    // one access; outputs sampled one cycle later at negedge
    task automatic acc(input logic wr, input logic [63:0] wd, input logic [1:0] lvl);
        @(negedge clk);
        acc_valid = 1; acc_write = wr; acc_wdata = wd; cur_level = lvl;
        @(negedge clk);
        acc_valid = 0;
    endtask

    task automatic expect_kind(input string tag, input logic [1:0] k, input logic [1:0] l);
        chk(resp_valid && resp_kind == k && resp_level == l, tag,
            {58'b0, resp_valid, resp_kind, 1'b0, resp_level}, {58'b0, 1'b1, k, 1'b0, l});
        chk(fault_undef == (k == 2'b01) && fault_trap == (k == 2'b10) &&
            resp_syndrome == ((k == 2'b10) ? 6'h18 : 6'h0), tag,
            {56'b0, fault_undef, fault_trap, resp_syndrome}, {56'b0, k == 2'b01, k == 2'b10,
            (k == 2'b10) ? 6'h18 : 6'h0});
    endtask

    task automatic read_l3(input string tag, input logic [63:0] exp);
        clr_ctl();
        acc(0, '0, 2'd3);
        chk(resp_valid && rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic t_reset();
        rx_full = 1; tx_full = 1;
        @(negedge clk);
        chk(irq_comb == 0, "R1 irq after reset", irq_comb, 0);
        chk(resp_valid == 0, "R1 no response after reset", resp_valid, 0);
        read_l3("R1 read after reset", 64'h0);
    endtask

    task automatic t_rx();
        clr_ctl(); rx_full = 0; tx_full = 0;
        acc(1, RXB, 2'd3);
        chk(irq_comb == 0, "R2 rx enabled, rx empty", irq_comb, 0);
        rx_full = 1; #1;
        chk(irq_comb == 1, "R2 rx enabled, rx full", irq_comb, 1);
        read_l3("R2 readback rx bit", RXB);
    endtask

    task automatic t_tx();
        clr_ctl(); rx_full = 1; tx_full = 1;
        acc(1, TXB, 2'd3);
        chk(irq_comb == 0, "R3 tx enabled, tx full, rx ignored", irq_comb, 0);
        tx_full = 0; #1;
        chk(irq_comb == 1, "R3 tx enabled, tx has room", irq_comb, 1);
    endtask

    task automatic t_reserved();
        clr_ctl();
        acc(1, '1, 2'd3);
        read_l3("R4 reserved bits read zero", BOTH);
        acc(1, ~BOTH, 2'd3);
        read_l3("R4 write of reserved only clears enables", 64'h0);
    endtask

    task automatic t_encoding();
        clr_ctl(); acc_crm = 4'd3;
        acc(1, BOTH, 2'd3);
        chk(resp_valid == 0, "R5 foreign encoding no response", resp_valid, 0);
        read_l3("R5 foreign encoding no write", 64'h0);
    endtask

    task automatic t_level0();
        clr_ctl();
        acc(0, '0, 2'd0);
        expect_kind("R6 level0 read", 2'b01, 2'd0);
        chk(rd_data == 0, "R12 level0 read data", rd_data, 0);
        @(negedge clk);
        chk(fault_undef == 0 && resp_valid == 0, "R13 one-cycle response", {fault_undef, resp_valid}, 0);
        clr_ctl(); core_halted = 1; ignore_traps_halted = 1;
        acc(1, BOTH, 2'd0);
        expect_kind("R6 level0 halted", 2'b01, 2'd0);
        read_l3("R12 level0 write blocked", 64'h0);
    endtask

    task automatic t_halted();
        clr_ctl(); core_halted = 1; ignore_traps_halted = 1;
        have_level3 = 1; fine_trap_feat = 1; level2_enabled = 1; l3_undef_prio = 1;
        l3_comm_trap = 1; l3_debug_trap = 1; l2_comm_trap = 1; l2_debug_trap = 1;
        acc(0, '0, 2'd1);
        expect_kind("R7 halted ignore traps", 2'b00, 2'd0);
        ignore_traps_halted = 0;
        acc(0, '0, 2'd1);
        expect_kind("R7 halted without option", 2'b01, 2'd0);
    endtask

    task automatic t_level1();
        clr_ctl(); have_level3 = 1; fine_trap_feat = 1; level2_enabled = 1;
        l3_undef_prio = 1; l3_comm_trap = 1; l2_comm_trap = 1;
        acc(0, '0, 2'd1);
        expect_kind("R8 comms undef beats level2", 2'b01, 2'd0);
        l3_comm_trap = 0; l3_debug_trap = 1; fine_trap_feat = 0; l2_comm_trap = 0; l2_debug_trap = 1;
        acc(0, '0, 2'd1);
        expect_kind("R8 debug undef beats level2", 2'b01, 2'd0);
        clr_ctl(); have_level3 = 1; fine_trap_feat = 1; level2_enabled = 1;
        l2_comm_trap = 1; l3_comm_trap = 1;
        acc(0, '0, 2'd1);
        expect_kind("R9 level2 comms trap", 2'b10, 2'd2);
        clr_ctl(); level2_enabled = 1; l2_comm_trap = 1;
        acc(0, '0, 2'd1);
        expect_kind("R9 comms trap needs feature", 2'b00, 2'd0);
        l2_dbgexc_route = 1;
        acc(0, '0, 2'd1);
        expect_kind("R9 level2 exception routing trap", 2'b10, 2'd2);
        level2_enabled = 0;
        acc(0, '0, 2'd1);
        expect_kind("R9 level2 disabled", 2'b00, 2'd0);
        clr_ctl(); have_level3 = 1; fine_trap_feat = 1; l3_comm_trap = 1;
        acc(0, '0, 2'd1);
        expect_kind("R10 level3 comms trap", 2'b10, 2'd3);
        l3_sdd_undef = 1;
        acc(0, '0, 2'd1);
        expect_kind("R10 secure debug disabled", 2'b01, 2'd0);
        clr_ctl(); l3_debug_trap = 1; l3_undef_prio = 1;
        acc(0, '0, 2'd1);
        expect_kind("R10 no level3 present", 2'b00, 2'd0);
    endtask

    task automatic t_level2_3();
        clr_ctl(); level2_enabled = 1; fine_trap_feat = 1; l2_comm_trap = 1; l2_debug_trap = 1;
        acc(0, '0, 2'd2);
        expect_kind("R11 level2 skips level2 traps", 2'b00, 2'd0);
        have_level3 = 1; l3_debug_trap = 1;
        acc(0, '0, 2'd2);
        expect_kind("R11 level2 trapped to level3", 2'b10, 2'd3);
        l3_undef_prio = 1; l3_comm_trap = 1;
        acc(0, '0, 2'd3);
        expect_kind("R11 level3 always completes", 2'b00, 2'd0);
    endtask

    task automatic t_fault_write();
        clr_ctl(); rx_full = 0; tx_full = 0;
        acc(1, BOTH, 2'd3);
        chk(irq_comb == 1, "R13 write visible on irq", irq_comb, 1);
        clr_ctl(); level2_enabled = 1; l2_debug_trap = 1;
        acc(1, 64'h0, 2'd1);
        expect_kind("R12 trapped write", 2'b10, 2'd2);
        chk(irq_comb == 1, "R12 trapped write kept state", irq_comb, 1);
        acc(0, 64'h0, 2'd1);
        chk(rd_data == 0, "R12 trapped read returns zero", rd_data, 0);
        @(negedge clk);
        chk(fault_trap == 0, "R12 trap pulse one cycle", fault_trap, 0);
        read_l3("R12 register unchanged", BOTH);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_rx();
        t_tx();
        t_reserved();
        t_encoding();
        t_level0();
        t_halted();
        t_level1();
        t_level2_3();
        t_fault_write();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R13 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule